// File: doc/BRIEF.md
# Near Call and Return Unit with Shadow Return Stack

This block executes the 32-bit near control transfers of a processor pipeline. It handles a relative call (next-instruction pointer plus a signed displacement), a register-indirect call (target taken from an operand) and a near return that can release a 16-bit count of extra stack bytes. It owns three architectural registers: the instruction pointer, the main stack pointer and a shadow stack pointer. It drives two word-wide stack memory ports, one for the main stack and one for the shadow stack.

When the shadow stack is enabled, calls also write the return address to the shadow stack, and returns read both copies and compare them. A mismatch raises a control-protection fault. A target or return address above the code segment limit raises a general-protection fault. A faulting instruction commits none of the three registers. A stack-size input selects between a 32-bit stack pointer and a 16-bit one held in the low half of the register.

A call completes in one cycle. A return takes two: it issues the reads in the accept cycle and evaluates them in the next cycle, which has synchronous read data. `req_ready` is low during that second cycle, and any request presented then is ignored.

Top module: `near_branch_shadow`

## Requirements
- R1: After reset the instruction pointer is IP_RESET (default 0), the stack pointer is SP_RESET (default 0x200), the shadow pointer is SSP_RESET (default 0x600), `req_ready` is 1, and `done`, `gp_fault` and `cp_fault` are 0.
- R2: A relative call (`req_op`=1) writes `next_ip` to the main stack at SP-4 in its accept cycle. On the next edge SP becomes SP-4 and the instruction pointer becomes `next_ip`+`operand` modulo 2^32, with `done` high for one cycle.
- R3: A register call (`req_op`=2) loads the instruction pointer with `operand`, and otherwise behaves as in R2.
- R4: With `shstk_en`=1, a register call writes `next_ip` to the shadow stack at SSP-4 and SSP drops by 4. With `shstk_en`=0 there is no shadow write and SSP is unchanged.
- R5: A relative call with `operand`=0 never writes the shadow stack and leaves SSP unchanged, even with `shstk_en`=1. A nonzero displacement with `shstk_en`=1 pushes as in R4.
- R6: A call whose target is above `cs_limit` raises `gp_fault` with `fault_code`=0 and leaves the instruction pointer, SP and SSP unchanged. A target equal to the limit is accepted.
- R7: A return (`req_op`=3) reads the main stack at SP. One cycle after the accept edge it loads the instruction pointer with the word read, sets SP to SP+4+`imm16`, and pulses `done`.
- R8: With `shstk_en`=1, a return also reads the shadow stack at SSP. On a match SSP rises by 4. On a mismatch `cp_fault` pulses with `fault_code`=1 (the near-return code), and the instruction pointer, SP and SSP are unchanged.
- R9: When the shadow copy mismatches and the return address is also above the limit, only `cp_fault` is raised. The two faults never pulse together.
- R10: A return address above `cs_limit` raises `gp_fault` with `fault_code`=0 and leaves all three registers unchanged.
- R11: With `stk32`=0 only SP[15:0] moves, wrapping modulo 2^16, and SP[31:16] is kept. The main stack address is then {16'h0, SP[15:0]} of the pushed or popped slot. With `stk32`=1 all 32 bits move and the address is SP itself.
- R12: `req_ready` is low for exactly the one cycle after a return is accepted. A request presented in that cycle causes no memory write and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 none, 1 relative call, 2 register call, 3 return |
| next_ip | input | 32 | Address of the following instruction |
| operand | input | 32 | Displacement (relative call) or target (register call) |
| imm16 | input | 16 | Extra bytes released by a return |
| shstk_en | input | 1 | Shadow stack enable |
| stk32 | input | 1 | 1: 32-bit stack pointer, 0: 16-bit |
| cs_limit | input | 32 | Highest legal code offset |
| req_ready | output | 1 | Block can accept a request |
| ms_wr_en | output | 1 | Main stack write strobe |
| ms_rd_en | output | 1 | Main stack read strobe |
| ms_addr | output | 32 | Main stack byte address |
| ms_wdata | output | 32 | Main stack write data |
| ms_rdata | input | 32 | Main stack read data, valid the cycle after `ms_rd_en` |
| ss_wr_en | output | 1 | Shadow stack write strobe |
| ss_rd_en | output | 1 | Shadow stack read strobe |
| ss_addr | output | 32 | Shadow stack byte address |
| ss_wdata | output | 32 | Shadow stack write data |
| ss_rdata | input | 32 | Shadow stack read data, valid the cycle after `ss_rd_en` |
| ip_out | output | 32 | Instruction pointer |
| sp_out | output | 32 | Main stack pointer |
| ssp_out | output | 32 | Shadow stack pointer |
| done | output | 1 | Instruction finished (with or without fault) |
| gp_fault | output | 1 | General-protection fault pulse |
| cp_fault | output | 1 | Control-protection fault pulse |
| fault_code | output | 16 | Code of the last fault |

## Verification
Several properties are checked on every cycle: a fault never moves any of the three registers, the two fault strobes are exclusive and always come with `done`, a shadow write always goes with a main write, the shadow pointer only ever steps by four, and the return wait lasts exactly one cycle. Only the directed scenarios can show that values are right: the computed targets, the popped addresses, the release arithmetic in both stack widths with the 16-bit wrap, the zero-displacement exception for shadow pushes, and the fault priority on a return that fails both checks.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    parameter int unsigned WORD_W  = 32;
    parameter int unsigned HALF_W  = 16;
    parameter int unsigned SLOT_B  = 4;
    parameter int unsigned FCODE_W = 16;

    localparam logic [FCODE_W-1:0] CODE_GP_ZERO    = '0;
    localparam logic [FCODE_W-1:0] CODE_CP_NEARRET = FCODE_W'(1);

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_CALL_REL = 2'd1,
        OP_CALL_REG = 2'd2,
        OP_RET      = 2'd3
    } nbs_op_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_RET_EVAL = 1'b1
    } nbs_state_e;

    typedef enum logic [1:0] {
        VERDICT_OK = 2'd0,
        VERDICT_GP = 2'd1,
        VERDICT_CP = 2'd2
    } nbs_verdict_e;

    // Request context held across the return evaluation cycle
    typedef struct packed {
        logic [WORD_W-1:0] limit;
        logic [HALF_W-1:0] release_bytes;
        logic              wide;
        logic              shadow;
    } nbs_ret_ctx_t;

    // Move a stack pointer; a narrow stack only changes its low half
    function automatic logic [WORD_W-1:0] sp_move(input logic [WORD_W-1:0] sp,
                                                  input logic [WORD_W-1:0] delta,
                                                  input logic wide);
        logic [HALF_W-1:0] low;
        low = sp[HALF_W-1:0] + delta[HALF_W-1:0];
        return wide ? (sp + delta) : {sp[WORD_W-1:HALF_W], low};
    endfunction

    // Bus address of a stack slot
    function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] sp,
                                                    input logic wide);
        return wide ? sp : {{(WORD_W-HALF_W){1'b0}}, sp[HALF_W-1:0]};
    endfunction
endpackage

// File: rtl/nbs_target_gen.sv
module nbs_target_gen
    import nbs_pkg::*;
(
    input  nbs_op_e           op,
    input  logic [WORD_W-1:0] next_ip,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] limit,
    input  logic              shadow_en,
    output logic [WORD_W-1:0] target,
    output logic              over_limit,
    output logic              shadow_push
);
    always_comb begin
        target      = (op == OP_CALL_REG) ? operand : (next_ip + operand);
        over_limit  = (target > limit);
        shadow_push = shadow_en &&
                      ((op == OP_CALL_REG) ||
                       ((op == OP_CALL_REL) && (operand != '0)));
    end
endmodule

// File: rtl/nbs_ret_judge.sv
module nbs_ret_judge
    import nbs_pkg::*;
(
    input  nbs_ret_ctx_t      ctx,
    input  logic [WORD_W-1:0] popped,
    input  logic [WORD_W-1:0] shadow_copy,
    output nbs_verdict_e      verdict
);
    // Shadow comparison outranks the limit check
    always_comb begin
        if (ctx.shadow && (popped != shadow_copy))
            verdict = VERDICT_CP;
        else if (popped > ctx.limit)
            verdict = VERDICT_GP;
        else
            verdict = VERDICT_OK;
    end
endmodule

// File: rtl/near_branch_shadow.sv
module near_branch_shadow
    import nbs_pkg::*;
#(
    parameter logic [31:0] IP_RESET  = 32'h0000_0000,
    parameter logic [31:0] SP_RESET  = 32'h0000_0200,
    parameter logic [31:0] SSP_RESET = 32'h0000_0600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [31:0] next_ip,
    input  logic [31:0] operand,
    input  logic [15:0] imm16,
    input  logic        shstk_en,
    input  logic        stk32,
    input  logic [31:0] cs_limit,
    output logic        req_ready,
    output logic        ms_wr_en,
    output logic        ms_rd_en,
    output logic [31:0] ms_addr,
    output logic [31:0] ms_wdata,
    input  logic [31:0] ms_rdata,
    output logic        ss_wr_en,
    output logic        ss_rd_en,
    output logic [31:0] ss_addr,
    output logic [31:0] ss_wdata,
    input  logic [31:0] ss_rdata,
    output logic [31:0] ip_out,
    output logic [31:0] sp_out,
    output logic [31:0] ssp_out,
    output logic        done,
    output logic        gp_fault,
    output logic        cp_fault,
    output logic [15:0] fault_code
);
    localparam logic [WORD_W-1:0] STEP_DN = WORD_W'(0) - WORD_W'(SLOT_B);
    localparam logic [WORD_W-1:0] STEP_UP = WORD_W'(SLOT_B);

    nbs_state_e        state_q;
    nbs_ret_ctx_t      ctx_q;
    logic [WORD_W-1:0] ip_q, sp_q, ssp_q;
    logic              done_q, gp_q, cp_q;
    logic [FCODE_W-1:0] code_q;

    nbs_op_e           op;
    logic              accept, is_call, is_ret;
    logic [WORD_W-1:0] target, sp_pushed;
    logic              over_limit, shadow_push;
    nbs_verdict_e      verdict;

    assign op = nbs_op_e'(req_op);

    nbs_target_gen u_tgt (
        .op          (op),
        .next_ip     (next_ip),
        .operand     (operand),
        .limit       (cs_limit),
        .shadow_en   (shstk_en),
        .target      (target),
        .over_limit  (over_limit),
        .shadow_push (shadow_push)
    );

    nbs_ret_judge u_judge (
        .ctx         (ctx_q),
        .popped      (ms_rdata),
        .shadow_copy (ss_rdata),
        .verdict     (verdict)
    );

    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE) && (op != OP_NONE);
        is_call   = accept && ((op == OP_CALL_REL) || (op == OP_CALL_REG));
        is_ret    = accept && (op == OP_RET);
        sp_pushed = sp_move(sp_q, STEP_DN, stk32);

        ms_wr_en  = is_call;
        ms_rd_en  = is_ret;
        ms_addr   = is_call ? slot_addr(sp_pushed, stk32) : slot_addr(sp_q, stk32);
        ms_wdata  = next_ip;

        ss_wr_en  = is_call && shadow_push;
        ss_rd_en  = is_ret && shstk_en;
        ss_addr   = is_call ? (ssp_q + STEP_DN) : ssp_q;
        ss_wdata  = next_ip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            ip_q    <= IP_RESET;
            sp_q    <= SP_RESET;
            ssp_q   <= SSP_RESET;
            done_q  <= 1'b0;
            gp_q    <= 1'b0;
            cp_q    <= 1'b0;
            code_q  <= '0;
        end else begin
            done_q <= 1'b0;
            gp_q   <= 1'b0;
            cp_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (is_call) begin
                        done_q <= 1'b1;
                        if (over_limit) begin
                            gp_q   <= 1'b1;
                            code_q <= CODE_GP_ZERO;
                        end else begin
                            ip_q <= target;
                            sp_q <= sp_pushed;
                            if (shadow_push)
                                ssp_q <= ssp_q + STEP_DN;
                        end
                    end else if (is_ret) begin
                        ctx_q.limit         <= cs_limit;
                        ctx_q.release_bytes <= imm16;
                        ctx_q.wide          <= stk32;
                        ctx_q.shadow        <= shstk_en;
                        state_q             <= ST_RET_EVAL;
                    end
                end
                ST_RET_EVAL: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    case (verdict)
                        VERDICT_CP: begin
                            cp_q   <= 1'b1;
                            code_q <= CODE_CP_NEARRET;
                        end
                        VERDICT_GP: begin
                            gp_q   <= 1'b1;
                            code_q <= CODE_GP_ZERO;
                        end
                        default: begin
                            ip_q <= ms_rdata;
                            sp_q <= sp_move(sp_move(sp_q, STEP_UP, ctx_q.wide),
                                            {{(WORD_W-HALF_W){1'b0}}, ctx_q.release_bytes},
                                            ctx_q.wide);
                            if (ctx_q.shadow)
                                ssp_q <= ssp_q + STEP_UP;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign ip_out     = ip_q;
    assign sp_out     = sp_q;
    assign ssp_out    = ssp_q;
    assign done       = done_q;
    assign gp_fault   = gp_q;
    assign cp_fault   = cp_q;
    assign fault_code = code_q;

    // R6 R8 R10: a faulting instruction commits nothing
    a_r6_fault_holds_state: assert property (@(posedge clk) disable iff (rst)
        (gp_q || cp_q) |-> ($stable(ip_q) && $stable(sp_q) && $stable(ssp_q)));

    // R9: fault strobes are exclusive
    a_r9_single_fault: assert property (@(posedge clk) disable iff (rst)
        !(gp_q && cp_q));

    // R10: a fault always ends an instruction
    a_r10_fault_with_done: assert property (@(posedge clk) disable iff (rst)
        (gp_q || cp_q) |-> done_q);

    // R4: a shadow push only accompanies a main push
    a_r4_shadow_with_main: assert property (@(posedge clk) disable iff (rst)
        ss_wr_en |-> ms_wr_en);

    // R8: the shadow pointer moves one slot at a time
    a_r8_ssp_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(ssp_q) |-> ((ssp_q == $past(ssp_q) + STEP_UP) ||
                             (ssp_q == $past(ssp_q) + STEP_DN)));

    // R12: the return wait lasts one cycle
    a_r12_one_wait: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    // R7: a return read is followed by the evaluation cycle
    a_r7_read_then_wait: assert property (@(posedge clk) disable iff (rst)
        ms_rd_en |=> !req_ready);
endmodule

// File: tb/near_branch_shadow_test.sv
module near_branch_shadow_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] next_ip = '0, operand = '0, cs_limit = 32'h0000_FFFF;
    logic [15:0] imm16 = '0;
    logic        shstk_en = 1'b0, stk32 = 1'b1;
    logic        req_ready, ms_wr_en, ms_rd_en, ss_wr_en, ss_rd_en;
    logic [31:0] ms_addr, ms_wdata, ms_rdata, ss_addr, ss_wdata, ss_rdata;
    logic [31:0] ip_out, sp_out, ssp_out;
    logic        done, gp_fault, cp_fault;
    logic [15:0] fault_code;

    int checks = 0;
    int fails  = 0;

    logic [31:0] main_mem [0:1023];
    logic [31:0] shad_mem [0:1023];

    always #4 clk = ~clk;

    near_branch_shadow uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .next_ip(next_ip), .operand(operand), .imm16(imm16),
        .shstk_en(shstk_en), .stk32(stk32), .cs_limit(cs_limit),
        .req_ready(req_ready),
        .ms_wr_en(ms_wr_en), .ms_rd_en(ms_rd_en), .ms_addr(ms_addr),
        .ms_wdata(ms_wdata), .ms_rdata(ms_rdata),
        .ss_wr_en(ss_wr_en), .ss_rd_en(ss_rd_en), .ss_addr(ss_addr),
        .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
        .ip_out(ip_out), .sp_out(sp_out), .ssp_out(ssp_out),
        .done(done), .gp_fault(gp_fault), .cp_fault(cp_fault),
        .fault_code(fault_code)
    );

    // Stack memories with one-cycle read latency
    always @(posedge clk) begin
        if (ms_wr_en) main_mem[ms_addr[11:2]] <= ms_wdata;
        if (ms_rd_en) ms_rdata <= main_mem[ms_addr[11:2]];
        if (ss_wr_en) shad_mem[ss_addr[11:2]] <= ss_wdata;
        if (ss_rd_en) ss_rdata <= shad_mem[ss_addr[11:2]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [31:0] ip, input logic [31:0] sp,
                             input logic [31:0] ssp);
        chk({tag, " ip"}, ip_out, ip);
        chk({tag, " sp"}, sp_out, sp);
        chk({tag, " ssp"}, ssp_out, ssp);
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] nip, input logic [31:0] opd,
                         input logic [15:0] imm, input logic sh, input logic w,
                         input logic [31:0] lim);
        req_valid = 1'b1; req_op = op; next_ip = nip; operand = opd;
        imm16 = imm; shstk_en = sh; stk32 = w; cs_limit = lim;
    endtask

    task automatic idle_bus();
        req_valid = 1'b0; req_op = 2'd0;
    endtask

    // One call; checks bus in the accept cycle, result after the edge
    task automatic do_call(input string tag, input logic [1:0] op, input logic [31:0] nip,
                           input logic [31:0] opd, input logic sh, input logic w,
                           input logic [31:0] lim, input logic exp_sw,
                           input logic [31:0] exp_maddr, input logic [31:0] exp_saddr);
        @(negedge clk);
        drive(op, nip, opd, 16'h0, sh, w, lim);
        #1;
        chk({tag, " main write"}, {31'b0, ms_wr_en}, 32'd1);
        chk({tag, " main addr"}, ms_addr, exp_maddr);
        chk({tag, " shadow write"}, {31'b0, ss_wr_en}, {31'b0, exp_sw});
        if (exp_sw) chk({tag, " shadow addr"}, ss_addr, exp_saddr);
        @(negedge clk);
        idle_bus();
        chk({tag, " done"}, {31'b0, done}, 32'd1);
    endtask

    // One return; leaves the bench just after the commit edge
    task automatic do_ret(input string tag, input logic [15:0] imm, input logic sh,
                          input logic w, input logic [31:0] lim,
                          input logic [31:0] exp_maddr, input logic [31:0] exp_saddr);
        @(negedge clk);
        drive(2'd3, 32'h0, 32'h0, imm, sh, w, lim);
        #1;
        chk({tag, " main read"}, {31'b0, ms_rd_en}, 32'd1);
        chk({tag, " main addr"}, ms_addr, exp_maddr);
        chk({tag, " shadow read"}, {31'b0, ss_rd_en}, {31'b0, sh});
        if (sh) chk({tag, " shadow addr"}, ss_addr, exp_saddr);
        @(negedge clk);
        idle_bus();
        chk({tag, " ready low"}, {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk({tag, " done"}, {31'b0, done}, 32'd1);
    endtask

    task automatic t_reset();
        chk_state("R1 reset", 32'h0, 32'h200, 32'h600);
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 flags", {29'b0, done, gp_fault, cp_fault}, 32'd0);
    endtask

    task automatic t_rel_calls();
        do_call("R2 rel call", 2'd1, 32'h1000, 32'h20, 1'b0, 1'b1, 32'hFFFF, 1'b0, 32'h1FC, 32'h0);
        chk_state("R2 rel call", 32'h1020, 32'h1FC, 32'h600);
        chk("R2 pushed word", main_mem[32'h1FC >> 2], 32'h1000);
        do_call("R5 rel neg disp", 2'd1, 32'h1100, 32'hFFFF_FFF0, 1'b1, 1'b1, 32'hFFFF, 1'b1, 32'h1F8, 32'h5FC);
        chk_state("R5 rel neg disp", 32'h10F0, 32'h1F8, 32'h5FC);
        chk("R5 shadow word", shad_mem[32'h5FC >> 2], 32'h1100);
        do_call("R5 zero disp", 2'd1, 32'h1200, 32'h0, 1'b1, 1'b1, 32'hFFFF, 1'b0, 32'h1F4, 32'h0);
        chk_state("R5 zero disp", 32'h1200, 32'h1F4, 32'h5FC);
    endtask

    task automatic t_reg_calls();
        do_call("R3 reg call shadow", 2'd2, 32'h1300, 32'h3000, 1'b1, 1'b1, 32'hFFFF, 1'b1, 32'h1F0, 32'h5F8);
        chk_state("R4 reg call shadow", 32'h3000, 32'h1F0, 32'h5F8);
        chk("R4 shadow word", shad_mem[32'h5F8 >> 2], 32'h1300);
        do_call("R4 reg call no shadow", 2'd2, 32'h1400, 32'h4000, 1'b0, 1'b1, 32'hFFFF, 1'b0, 32'h1EC, 32'h0);
        chk_state("R4 reg call no shadow", 32'h4000, 32'h1EC, 32'h5F8);
    endtask

    task automatic t_call_limit();
        do_call("R6 target at limit", 2'd2, 32'h1500, 32'h2FFF, 1'b0, 1'b1, 32'h2FFF, 1'b0, 32'h1E8, 32'h0);
        chk_state("R6 target at limit", 32'h2FFF, 32'h1E8, 32'h5F8);
        chk("R6 no fault at limit", {30'b0, gp_fault, cp_fault}, 32'd0);
        do_call("R6 over limit", 2'd2, 32'h1600, 32'h3000, 1'b1, 1'b1, 32'h2FFF, 1'b1, 32'h1E4, 32'h5F4);
        chk("R6 gp", {30'b0, gp_fault, cp_fault}, 32'd2);
        chk("R6 code", {16'b0, fault_code}, 32'd0);
        chk_state("R6 unchanged", 32'h2FFF, 32'h1E8, 32'h5F8);
    endtask

    task automatic t_ret_basic();
        // R12: a call offered during the wait cycle is ignored
        @(negedge clk);
        drive(2'd3, 32'h0, 32'h0, 16'h0, 1'b0, 1'b1, 32'hFFFF);
        @(negedge clk);
        drive(2'd2, 32'h7700, 32'h7000, 16'h0, 1'b0, 1'b1, 32'hFFFF);
        #1;
        chk("R12 ready low", {31'b0, req_ready}, 32'd0);
        chk("R12 no write", {30'b0, ms_wr_en, ss_wr_en}, 32'd0);
        @(negedge clk);
        idle_bus();
        chk_state("R7 ret", 32'h1500, 32'h1EC, 32'h5F8);
        @(negedge clk);
        chk_state("R12 ignored call", 32'h1500, 32'h1EC, 32'h5F8);
        do_ret("R7 ret release", 16'h8, 1'b0, 1'b1, 32'hFFFF, 32'h1EC, 32'h0);
        chk_state("R7 ret release", 32'h1400, 32'h1F8, 32'h5F8);
    endtask

    task automatic t_ret_faults();
        do_ret("R8 mismatch", 16'h0, 1'b1, 1'b1, 32'hFFFF, 32'h1F8, 32'h5F8);
        chk("R8 cp", {30'b0, gp_fault, cp_fault}, 32'd1);
        chk("R8 code", {16'b0, fault_code}, 32'd1);
        chk_state("R8 unchanged", 32'h1400, 32'h1F8, 32'h5F8);
        do_ret("R9 both", 16'h0, 1'b1, 1'b1, 32'h0FFF, 32'h1F8, 32'h5F8);
        chk("R9 cp only", {30'b0, gp_fault, cp_fault}, 32'd1);
        chk_state("R9 unchanged", 32'h1400, 32'h1F8, 32'h5F8);
        do_ret("R10 over limit", 16'h0, 1'b0, 1'b1, 32'h10FF, 32'h1F8, 32'h0);
        chk("R10 gp", {30'b0, gp_fault, cp_fault}, 32'd2);
        chk("R10 code", {16'b0, fault_code}, 32'd0);
        chk_state("R10 unchanged", 32'h1400, 32'h1F8, 32'h5F8);
    endtask

    task automatic t_ret_match();
        do_call("R8 call", 2'd2, 32'h1600, 32'h5000, 1'b1, 1'b1, 32'hFFFF, 1'b1, 32'h1F4, 32'h5F4);
        do_ret("R8 match", 16'h10, 1'b1, 1'b1, 32'hFFFF, 32'h1F4, 32'h5F4);
        chk("R8 no fault", {30'b0, gp_fault, cp_fault}, 32'd0);
        chk_state("R8 match", 32'h1600, 32'h208, 32'h5F8);
    endtask

    task automatic t_narrow_stack();
        do_ret("R11 wide release", 16'hFFFC, 1'b0, 1'b1, 32'hFFFF, 32'h208, 32'h0);
        chk_state("R11 wide release", 32'h0, 32'h1_0208, 32'h5F8);
        do_call("R11 narrow call", 2'd1, 32'h1700, 32'h10, 1'b0, 1'b0, 32'hFFFF, 1'b0, 32'h204, 32'h0);
        chk_state("R11 narrow call", 32'h1710, 32'h1_0204, 32'h5F8);
        do_ret("R11 narrow ret", 16'hFF00, 1'b0, 1'b0, 32'hFFFF, 32'h204, 32'h0);
        chk_state("R11 narrow wrap", 32'h1700, 32'h1_0108, 32'h5F8);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            main_mem[i] = '0;
            shad_mem[i] = '0;
        end
        ms_rdata = '0;
        ss_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_rel_calls();
        t_reg_calls();
        t_call_limit();
        t_ret_basic();
        t_ret_faults();
        t_ret_match();
        t_narrow_stack();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1-flow actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule